// File: doc/BRIEF.md
# Serial Front-End Configuration Port with Crosspoint Decoder

This block is the digital configuration slave of an eight-channel receive front end. A host writes 40-bit frames over a four-wire serial link: an active-low select, a serial clock, a data input and a separate data output. The port has no fixed framing edge. After the select goes low, zero bits are ignored, and the first 1 bit opens a frame. The next 39 bits complete it. When the last bit arrives, the frame is decoded into a control word and into eight 4-bit routing codes.

The control word holds a global power-off flag, a mode flag, a 2-bit attenuation range and a 2-bit amplifier gain. The mode flag selects either time-gain mode or continuous-wave mode. Each routing code steers one channel onto one of ten summing outputs, or onto none of them. The codes are decoded into an 8 x 10 matrix of switch enables. The data output always presents the oldest bit of the 40-bit shift chain. The host can therefore read back what it shifted in, in the same order, while it clocks further zero bits.

The whole block runs on the serial clock. Input bits are taken on the rising edge. The data output moves on the falling edge. The link has no flow control: one bit is consumed on every rising edge while the select is low.

Top module: `serial_afe_ctl`

## Requirements
- R1: After reset the outputs are: pwr_off=1, tgc_mode=0, atten_sel=0, pga_gain=0, all switch enables 0 and sdo=0. The reset value of every routing code is 15.
- R2: While no frame is open and cs_n is low, a 0 on sdi is ignored. The first 1 sampled becomes the start bit and is bit 0 of a new frame.
- R3: A frame is 40 bits, sent LSB first; bit 0 is the start bit. The control byte occupies frame bits 7:0, with these fields:
  - bit 1: write flag
  - bit 2: power-off
  - bits 4:3: attenuation range
  - bit 5: mode (1 = time-gain, 0 = continuous-wave)
  - bits 7:6: gain

  The control outputs take their new values on the rising edge that samples the 40th bit.
- R4: The routing code of channel c (c = 0..7) is frame bits 8+4c+3 down to 8+4c.
- R5: For each channel, a code k in 0..9 sets switch enable sw_en[c*10+k] and leaves the other nine enables of that row clear. A code of 10..15 clears the whole row. At most one enable per row is ever set.
- R6: When the write flag is 0, the routing codes keep their previous values. The control byte fields are still updated.
- R7: The shift chain advances on every rising edge while cs_n is low. sdo shows the oldest bit of the chain and changes only on the falling edge. After a frame, bit k of that frame appears on sdo after k further rising edges.
- R8: If cs_n rises before the 40th bit, the partial frame is dropped. No output changes, and the next frame again waits for a start bit.
- R9: With cs_n held low, frames may follow one another. Each frame begins at its own start bit, which may come directly after the previous frame's last bit or after any number of zeros.
- R10: Every switch enable is 0 while pwr_off=1 or tgc_mode=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock; input taken on rising edge, output moved on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select; may stay low across frames |
| sdi | input | 1 | Serial data in, LSB of byte 1 first |
| sdo | output | 1 | Serial data out, oldest bit of the shift chain |
| pwr_off | output | 1 | 1 = whole front end powered down |
| tgc_mode | output | 1 | 1 = time-gain mode, 0 = continuous-wave mode |
| atten_sel | output | 2 | Maximum attenuation range select |
| pga_gain | output | 2 | Post-amplifier gain select |
| sw_en | output | 80 | Crosspoint enables, bit c*10+k joins channel c to summing output k |

## Verification
The assertions assume that cs_n and sdi change only away from the rising serial-clock edge. They also assume that reset is released while the clock runs, so the falling-edge output register follows the chain from the first cycle. The bench drives every input just after a falling edge and reads results one nanosecond later. This keeps all stimulus well clear of the sampling edge. Random frames always carry a 1 in bit 0, and random zero preambles of varied length precede them, so the start search and the back-to-back path are both covered.

// File: rtl/afe_ctl_pkg.sv
package afe_ctl_pkg;
  // Control byte field positions inside the received frame.
  localparam int CTRL_W     = 8;
  localparam int BIT_START  = 0;
  localparam int BIT_WRITE  = 1;
  localparam int BIT_PWROFF = 2;
  localparam int BIT_ATT_LO = 3;
  localparam int BIT_MODE   = 5;
  localparam int BIT_GN_LO  = 6;
  localparam int FLD2_W     = 2;

  typedef struct packed {
    logic [FLD2_W-1:0] gain;
    logic              tgc;
    logic [FLD2_W-1:0] att;
    logic              pwr_off;
  } ctrl_t;
endpackage

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int FRAME_W = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               din,
  output logic [FRAME_W-1:0] frame_nxt,
  output logic               frame_done,
  output logic               dout
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] chain_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               busy_q;
  logic               take_start;
  logic               dout_q;

  // Newest bit enters at the top, oldest bit leaves at bit 0.
  always_comb begin
    frame_nxt  = {din, chain_q[FRAME_W-1:1]};
    take_start = !cs_n && !busy_q && din;
    frame_done = !cs_n && busy_q && (cnt_q == LAST_IDX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
    end else if (cs_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      chain_q <= frame_nxt;
      if (take_start) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(1);
      end else if (frame_done) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) dout_q <= 1'b0;
    else        dout_q <= chain_q[0];
  end

  assign dout = dout_q;

  a_r8_deselect_closes: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !busy_q);
  a_r2_zero_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !busy_q && !din) |=> !busy_q);
  a_r9_done_reopens: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (!busy_q && cnt_q == '0));
  a_r7_out_tracks_chain: assert property (@(posedge clk) disable iff (!rst_n)
    dout_q == chain_q[0]);
endmodule

// File: rtl/control_latch.sv
module control_latch
  import afe_ctl_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CODE_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frame_done,
  input  logic [CTRL_W+NUM_CH*CODE_W-1:0] frame,
  output ctrl_t                    ctrl,
  output logic [NUM_CH*CODE_W-1:0] codes
);
  localparam int ROUTE_W = NUM_CH * CODE_W;

  ctrl_t              ctrl_q;
  logic [ROUTE_W-1:0] codes_q;
  logic               accept;

  assign accept = frame_done && frame[BIT_START];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '{gain: '0, tgc: 1'b0, att: '0, pwr_off: 1'b1};
      codes_q <= '1;
    end else if (accept) begin
      ctrl_q.pwr_off <= frame[BIT_PWROFF];
      ctrl_q.att     <= frame[BIT_ATT_LO +: FLD2_W];
      ctrl_q.tgc     <= frame[BIT_MODE];
      ctrl_q.gain    <= frame[BIT_GN_LO +: FLD2_W];
      if (frame[BIT_WRITE]) codes_q <= frame[CTRL_W +: ROUTE_W];
    end
  end

  assign ctrl  = ctrl_q;
  assign codes = codes_q;

  a_r6_read_keeps_routes: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !frame[BIT_WRITE]) |=> $stable(codes_q));
  a_r3_ctrl_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (ctrl_q.pwr_off == $past(frame[BIT_PWROFF]) &&
                ctrl_q.tgc == $past(frame[BIT_MODE])));
  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> ($stable(codes_q) && $stable(ctrl_q)));
endmodule

// File: rtl/route_decoder.sv
module route_decoder #(
  parameter int NUM_CH  = 8,
  parameter int NUM_OUT = 10,
  parameter int CODE_W  = 4
) (
  input  logic [NUM_CH*CODE_W-1:0]  codes,
  input  logic                      gate_off,
  output logic [NUM_CH*NUM_OUT-1:0] sw_en
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_row
    logic [CODE_W-1:0] code;
    assign code = codes[c*CODE_W +: CODE_W];
    for (genvar k = 0; k < NUM_OUT; k++) begin : g_col
      assign sw_en[c*NUM_OUT + k] = !gate_off && (code == CODE_W'(k));
    end
  end
endmodule

// File: rtl/serial_afe_ctl.sv
module serial_afe_ctl
  import afe_ctl_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int NUM_OUT = 10,
  parameter int CODE_W  = 4
) (
  input  logic                      sclk,
  input  logic                      rst_n,
  input  logic                      cs_n,
  input  logic                      sdi,
  output logic                      sdo,
  output logic                      pwr_off,
  output logic                      tgc_mode,
  output logic [1:0]                atten_sel,
  output logic [1:0]                pga_gain,
  output logic [NUM_CH*NUM_OUT-1:0] sw_en
);
  localparam int FRAME_W = CTRL_W + NUM_CH * CODE_W;

  logic [FRAME_W-1:0]       frame_nxt;
  logic                     frame_done;
  ctrl_t                    ctrl;
  logic [NUM_CH*CODE_W-1:0] codes;

  frame_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk(sclk), .rst_n(rst_n), .cs_n(cs_n), .din(sdi),
    .frame_nxt(frame_nxt), .frame_done(frame_done), .dout(sdo)
  );

  control_latch #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_latch (
    .clk(sclk), .rst_n(rst_n), .frame_done(frame_done),
    .frame(frame_nxt), .ctrl(ctrl), .codes(codes)
  );

  route_decoder #(.NUM_CH(NUM_CH), .NUM_OUT(NUM_OUT), .CODE_W(CODE_W)) u_dec (
    .codes(codes), .gate_off(ctrl.pwr_off || ctrl.tgc), .sw_en(sw_en)
  );

  assign pwr_off   = ctrl.pwr_off;
  assign tgc_mode  = ctrl.tgc;
  assign atten_sel = ctrl.att;
  assign pga_gain  = ctrl.gain;

  a_r10_gated: assert property (@(posedge sclk) disable iff (!rst_n)
    (pwr_off || tgc_mode) |-> (sw_en == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_row_chk
    a_r5_row_onehot: assert property (@(posedge sclk) disable iff (!rst_n)
      $onehot0(sw_en[c*NUM_OUT +: NUM_OUT]));
  end
endmodule

// File: tb/serial_afe_ctl_tb_top.sv
module serial_afe_ctl_tb_top;
  localparam int NCH = 8;
  localparam int NOUT = 10;
  localparam int FW = 40;

  logic sclk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic sdo, pwr_off, tgc_mode;
  logic [1:0] atten_sel, pga_gain;
  logic [NCH*NOUT-1:0] sw_en;

  int n_tests = 0, n_fail = 0;
  logic m_pwr = 1'b1, m_tgc = 1'b0;
  logic [1:0] m_att = '0, m_gain = '0;
  logic [31:0] m_codes = '1;

  always #4 sclk = ~sclk;

  serial_afe_ctl dut_i (
    .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .sdi(sdi), .sdo(sdo),
    .pwr_off(pwr_off), .tgc_mode(tgc_mode), .atten_sel(atten_sel),
    .pga_gain(pga_gain), .sw_en(sw_en)
  );

  function automatic logic [79:0] exp_sw(input logic [31:0] cd, input logic p, input logic t);
    logic [79:0] r = '0;
    for (int c = 0; c < NCH; c++) begin
      int k = int'(cd[c*4 +: 4]);
      if (!p && !t && k < NOUT) r[c*NOUT + k] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [39:0] mk(input logic wr, input logic p, input logic [1:0] a,
                                     input logic t, input logic [1:0] g, input logic [31:0] cd);
    return {cd, g, t, a, p, wr, 1'b1};
  endfunction

  task automatic chk(input string req, input string what, input logic [79:0] act, input logic [79:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "pwr_off", 80'(pwr_off), 80'(m_pwr));
    chk(req, "tgc_mode", 80'(tgc_mode), 80'(m_tgc));
    chk(req, "atten_sel", 80'(atten_sel), 80'(m_att));
    chk(req, "pga_gain", 80'(pga_gain), 80'(m_gain));
    chk(req, "sw_en", sw_en, exp_sw(m_codes, m_pwr, m_tgc));
  endtask

  task automatic model_apply(input logic [39:0] f);
    m_pwr = f[2]; m_att = f[4:3]; m_tgc = f[5]; m_gain = f[7:6];
    if (f[1]) m_codes = f[39:8];
  endtask

  task automatic bit_in(input logic b);
    sdi = b;
    @(posedge sclk);
    @(negedge sclk);
    #1;
  endtask

  task automatic send(input logic [39:0] f, input int lead);
    cs_n = 1'b0;
    repeat (lead) bit_in(1'b0);
    for (int i = 0; i < FW; i++) bit_in(f[i]);
    model_apply(f);
  endtask

  task automatic readback(input logic [39:0] f);
    for (int k = 0; k < FW; k++) begin
      chk("R7", $sformatf("sdo bit %0d", k), 80'(sdo), 80'(f[k]));
      sdi = 1'b0;
      @(posedge sclk);
      #1;
      if (k < 3) chk("R7", "sdo stable past rising edge", 80'(sdo), 80'(f[k]));
      @(negedge sclk);
      #1;
    end
  endtask

  initial begin : watchdog
    #(8 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [39:0] f, fa, fb;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge sclk);
    #1 rst_n = 1'b1;
    // R1 reset state
    check_all("R1");
    chk("R1", "sdo", 80'(sdo), 80'(0));
    // R2 R3 R4 R5: leading zeros, codes 0..7 per channel
    f = mk(1, 0, 2'b10, 0, 2'b01, 32'h7654_3210);
    send(f, 5);
    check_all("R3");
    chk("R4", "channel 0 to output 0", 80'(sw_en[0]), 80'(1));
    chk("R4", "channel 7 to output 7", 80'(sw_en[7*NOUT+7]), 80'(1));
    // R7 readback of the chain
    readback(f);
    check_all("R2");
    // R5 upper codes 8,9 and tied-off codes 10..15
    f = mk(1, 0, 2'b11, 0, 2'b11, 32'hFEDC_BA98);
    send(f, 0);
    check_all("R5");
    chk("R5", "rows 2..7 tied off", 80'(sw_en[79:20]), 80'(0));
    // R6 read frame: control updates, routes kept
    f = mk(0, 0, 2'b01, 0, 2'b10, 32'h0123_4567);
    send(f, 2);
    check_all("R6");
    // R8 abort mid-frame
    fa = mk(1, 1, 2'b00, 1, 2'b00, 32'h1111_1111);
    cs_n = 1'b0;
    for (int i = 0; i < 20; i++) bit_in(fa[i]);
    cs_n = 1'b1;
    bit_in(1'b0); bit_in(1'b0);
    check_all("R8");
    f = mk(1, 0, 2'b00, 0, 2'b00, 32'h9999_0000);
    send(f, 1);
    check_all("R8");
    // R9 back-to-back with select held low
    fa = mk(1, 0, 2'b01, 0, 2'b01, 32'h2468_1357);
    fb = mk(1, 0, 2'b10, 0, 2'b10, 32'h0246_8135);
    send(fa, 0);
    check_all("R9");
    send(fb, 0);
    check_all("R9");
    send(fa, 3);
    check_all("R9");
    // R10 gating by mode and by power
    send(mk(1, 0, 2'b00, 1, 2'b00, 32'h3333_3333), 0);
    chk("R10", "tgc gates", sw_en, 80'(0));
    send(mk(1, 1, 2'b00, 0, 2'b00, 32'h4444_4444), 0);
    chk("R10", "pwr gates", sw_en, 80'(0));
    send(mk(0, 0, 2'b00, 0, 2'b00, 32'h0), 0);
    check_all("R10");
    // Random frames
    for (int it = 0; it < 60; it++) begin
      logic [31:0] cd;
      for (int c = 0; c < NCH; c++)
        cd[c*4 +: 4] = ($urandom % 4 == 0) ? 4'(10 + $urandom % 6) : 4'($urandom % 10);
      f = mk(1'($urandom), 1'($urandom % 4 == 0), 2'($urandom), 1'($urandom % 4 == 0),
             2'($urandom), cd);
      if ($urandom % 5 == 0) begin
        cs_n = 1'b0;
        for (int i = 0; i < int'($urandom % 39) + 1; i++) bit_in(f[i]);
        cs_n = 1'b1;
        bit_in(1'b0);
        check_all("R8");
      end
      send(f, int'($urandom % 6));
      check_all("R5");
      if (it % 15 == 0) readback(f);
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule